// File: doc/BRIEF.md
# Synchronous FIFO with Echoed Read Strobe

This block is a single-clock first-in, first-out buffer whose read side is registered and is paired with an active-low echo strobe. Each time a word leaves the buffer, the read data register loads that word. On the same rising edge the echo strobe falls for one clock. A receiver downstream can therefore capture the data with the strobe alone and does not need to rebuild the read handshake. A free-running copy of the clock comes out next to the strobe, so the receiver has a clock that travels with the data.

Writes are requested with an active-low enable. Reads need both an active-low read enable and an active-low chip select. The back-pressure rules are plain. A write is accepted only while the full flag is low and is otherwise dropped. A read is accepted only while the empty flag is low and the chip select is low. A refused request leaves the buffer, the read data and the pointers untouched. The echo strobe reports whether a read was accepted, so the strobe stands in for a valid signal on the read side. No ready signal exists on that side.

Top module: `efifo_echo`

## Requirements
- R1: While `rst` is high at a rising edge, the buffer is emptied. After that edge `empty` is 1, `full` is 0, `echo_rd_n` is 1 and `rd_data` is all zeros.
- R2: A read is accepted at a rising edge when `rd_en_n` is 0, `rd_cs_n` is 0 and `empty` is 0. After that edge `echo_rd_n` is 0 and `rd_data` holds the oldest stored word. Both change on the same edge.
- R3: After any rising edge with no accepted read, `echo_rd_n` is 1. This means the strobe is low for exactly one cycle per word.
- R4: A read request while `empty` is 1 is ignored. `rd_data` keeps its value and no word is consumed.
- R5: While `rd_cs_n` is 1, a low `rd_en_n` does not advance the read side. `rd_data` holds, and the next accepted read returns the word that was waiting.
- R6: Words are read out in the order in which they were accepted.
- R7: `empty` is registered. It falls on the rising edge that accepts the first write into an empty buffer, and it rises on the edge that takes out the last word.
- R8: `full` rises on the edge that accepts the DEPTH-th stored word. A write while `full` is 1 and no read is accepted is dropped, and the stored words are unaffected.
- R9: A write and a read accepted on the same edge while the buffer is neither empty nor full leave the occupancy unchanged, so `empty` and `full` keep their values.
- R10: `echo_clk` follows `clk` at all times, whatever `rd_en_n` and `rd_cs_n` are doing.
- R11: DATA_W must be 72, 36 or 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Active-low read request |
| rd_cs_n | input | 1 | Active-low read chip select |
| rd_data | output | DATA_W | Registered read word |
| empty | output | 1 | Registered empty flag |
| full | output | 1 | Registered full flag |
| echo_rd_n | output | 1 | Active-low strobe, low for the cycle a new word is shown |
| echo_clk | output | 1 | Free-running copy of `clk` |

## Verification
The bench reads from an empty buffer right after reset and right after draining. A design that let such a read through would pulse the strobe or repeat a stale word, and the scoreboard would pop a word from an empty queue. It holds the chip select high while the read enable is low. A design that ignored the select would consume a word, and the next read would return the following word out of order. It fills the buffer past DEPTH and then drains it. An overwrite on full would show up as a corrupted first word, and a late or early flag shows up at the edge where the count crosses. Mixed cycles that read and write together check that the flags do not move. A strobe that is held for an extra cycle or that leads the data by a cycle is caught because the strobe and the data are compared on every edge.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
  function automatic bit legal_width(input int w);
    return (w == 72) || (w == 36) || (w == 18);
  endfunction

  typedef struct packed {
    logic wr_fire;
    logic rd_fire;
  } xfer_t;
endpackage

// File: rtl/efifo_store.sv
module efifo_store #(
  parameter int DATA_W = 72,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/efifo_ctrl.sv
module efifo_ctrl
  import efifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output xfer_t         xfer,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          empty,
  output logic          full
);
  logic [CW-1:0] count_q, count_d;

  assign xfer.wr_fire = wr_req && !full;
  assign xfer.rd_fire = rd_req && !empty;

  always_comb begin
    count_d = count_q;
    case ({xfer.wr_fire, xfer.rd_fire})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      waddr   <= '0;
      raddr   <= '0;
      empty   <= 1'b1;
      full    <= 1'b0;
    end else begin
      count_q <= count_d;
      if (xfer.wr_fire) waddr <= (waddr == AW'(DEPTH - 1)) ? '0 : waddr + AW'(1);
      if (xfer.rd_fire) raddr <= (raddr == AW'(DEPTH - 1)) ? '0 : raddr + AW'(1);
      empty   <= (count_d == '0);
      full    <= (count_d == CW'(DEPTH));
    end
  end
endmodule

// File: rtl/efifo_out.sv
module efifo_out #(
  parameter int DATA_W = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              echo_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      echo_n <= 1'b1;
    end else begin
      echo_n <= !rd_fire;
      if (rd_fire) dout <= din;
    end
  end
endmodule

// File: rtl/efifo_echo.sv
module efifo_echo
  import efifo_pkg::*;
#(
  parameter int DATA_W = 72,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              rd_cs_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              echo_rd_n,
  output logic              echo_clk
);
  xfer_t             xfer;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] head;

  efifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .wr_req (!wr_en_n),
    .rd_req (!rd_en_n && !rd_cs_n),
    .xfer   (xfer),
    .waddr  (waddr),
    .raddr  (raddr),
    .empty  (empty),
    .full   (full)
  );

  efifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk   (clk),
    .we    (xfer.wr_fire),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (head)
  );

  efifo_out #(.DATA_W(DATA_W)) out_i (
    .clk     (clk),
    .rst     (rst),
    .rd_fire (xfer.rd_fire),
    .din     (head),
    .dout    (rd_data),
    .echo_n  (echo_rd_n)
  );

  assign echo_clk = clk;
endmodule

// File: rtl/efifo_echo_chk.sv
module efifo_echo_chk #(
  parameter int DATA_W = 72
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              rd_cs_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              empty,
  input logic              full,
  input logic              echo_rd_n
);
  logic take, put;
  assign take = !rd_en_n && !rd_cs_n && !empty;
  assign put  = !wr_en_n && !full;

  initial begin
    AST_LEGAL_WIDTH: assert (efifo_pkg::legal_width(DATA_W)); // R11
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (empty && !full && echo_rd_n && rd_data == '0)); // R1

  AST_ECHO_ON_READ: assert property (@(posedge clk) disable iff (rst)
    take |=> !echo_rd_n); // R2

  AST_ECHO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !take |=> echo_rd_n); // R3

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rd_data)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> full); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R7

  AST_RW_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (put && take) |=> (!empty && !full)); // R9
endmodule

bind efifo_echo efifo_echo_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en_n   (wr_en_n),
  .rd_en_n   (rd_en_n),
  .rd_cs_n   (rd_cs_n),
  .rd_data   (rd_data),
  .empty     (empty),
  .full      (full),
  .echo_rd_n (echo_rd_n)
);

// File: tb/efifo_echo_tb_top.sv
module efifo_echo_tb_top;
  localparam int W = 72;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, rd_cs_n = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic empty, full, echo_rd_n, echo_clk;

  always #5 clk = ~clk;

  efifo_echo #(.DATA_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rd_data(rd_data),
    .empty(empty), .full(full), .echo_rd_n(echo_rd_n), .echo_clk(echo_clk)
  );

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] sb[$];
  int cnt = 0;
  logic [W-1:0] exp_data = '0;
  logic exp_echo = 1'b1;
  logic pending = 1'b0;
  string tag = "R1";

  task automatic check(input bit ok, input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; updates the scoreboard model.
  task automatic cyc(input bit wr, input logic [W-1:0] wd, input bit rd, input bit cs, input string t);
    bit rd_ok, wr_ok;
    @(negedge clk);
    wr_en_n = !wr; wr_data = wd; rd_en_n = !rd; rd_cs_n = !cs; rst = 1'b0;
    rd_ok = rd && cs && (cnt > 0);
    wr_ok = wr && (cnt < D);
    if (rd_ok) exp_data = sb.pop_front();
    if (wr_ok) sb.push_back(wd);
    cnt = cnt + (wr_ok ? 1 : 0) - (rd_ok ? 1 : 0);
    exp_echo = !rd_ok;
    tag = t;
    pending = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; rd_cs_n = 1'b1;
    sb.delete(); cnt = 0; exp_data = '0; exp_echo = 1'b1; tag = "R1";
    pending = 1'b1;
  endtask

  function automatic logic [W-1:0] word(input int i);
    return {8{9'(i)}} ^ 72'hA5_5A5A_5A5A_5A5A_5A5A;
  endfunction

  // Monitor: compares outputs shortly after every rising edge.
  always @(posedge clk) begin
    #2;
    if (pending) begin
      check(echo_rd_n === exp_echo, {tag, " echo"}, W'(echo_rd_n), W'(exp_echo));
      check(rd_data === exp_data, {tag, " data"}, rd_data, exp_data);
      check(empty === (cnt == 0), {tag, " R7 empty"}, W'(empty), W'(cnt == 0));
      check(full === (cnt == D), {tag, " R8 full"}, W'(full), W'(cnt == D));
      check(echo_clk === 1'b1, "R10 echo_clk high", W'(echo_clk), W'(1));
    end
  end

  always @(negedge clk) begin
    #1;
    if (pending) check(echo_clk === 1'b0, "R10 echo_clk low", W'(echo_clk), W'(0));
  end

  initial begin
    fork
      begin
        do_reset(); do_reset();
        // R4: read on empty after reset
        cyc(0, '0, 1, 1, "R4");
        cyc(0, '0, 1, 1, "R4");
        // R7: first write clears empty
        cyc(1, word(1), 0, 0, "R7");
        // R5: select high blocks read
        cyc(0, '0, 1, 0, "R5");
        cyc(0, '0, 1, 0, "R5");
        // R2: accepted read
        cyc(0, '0, 1, 1, "R2");
        // R3/R4: read on drained buffer
        cyc(0, '0, 1, 1, "R3");
        cyc(0, '0, 0, 0, "R3");
        // R8: fill past depth
        for (int i = 0; i < D + 3; i++) cyc(1, word(100 + i), 0, 0, "R8");
        // R9: read and write together while full is a read only; then mixed
        cyc(1, word(300), 1, 1, "R8");
        cyc(1, word(301), 1, 1, "R9");
        cyc(1, word(302), 1, 1, "R9");
        // R6: drain with gaps
        for (int i = 0; i < D + 2; i++) begin
          cyc(0, '0, 1, 1, "R6");
          if (i % 3 == 0) cyc(0, '0, 0, 1, "R3");
        end
        // R9: streaming at occupancy one
        cyc(1, word(400), 0, 0, "R9");
        for (int i = 0; i < 6; i++) cyc(1, word(401 + i), 1, 1, "R9");
        cyc(0, '0, 1, 1, "R6");
        cyc(0, '0, 1, 1, "R4");
        // R1: reset in the middle of traffic
        cyc(1, word(500), 0, 0, "R1");
        cyc(1, word(501), 0, 0, "R1");
        do_reset();
        cyc(0, '0, 1, 1, "R1");
        cyc(0, '0, 0, 0, "R1");
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    disable fork;
    #10;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule